// File: doc/BRIEF.md
# Tagged IO Translation Cache

This block is a small, fully associative store of IO address translations for an IOMMU. Every entry is keyed by a 2-bit translation kind, a guest context ID, a process context ID and a virtual page number, and carries a physical page number and a permission code. Because the translation kind is part of the key, an invalidation scoped by context IDs removes only entries of the kind it names. Two translations that share IDs but differ in kind, such as a single-stage mapping and a nested mapping, are therefore kept apart.

A requester raises a lookup with the current kind, IDs and page number and gets a registered response one cycle later. A page walker outside this block installs results through the fill port. The command logic drives the invalidation port, whose field-enable bits select which of the guest ID, process ID and page number take part in the compare. A small combinational decoder turns the first-stage and guest-stage mode fields into the translation kind for the other ports.

The lookup request is a valid/ready stream. Its ready is held high because the cache never stalls, so a request is accepted in every cycle its valid is high. The response has no ready, and the requester must take it in the cycle it is valid. Fill and invalidation are single-cycle pulses and are never refused.

Top module: `xlat_tag_cache`

## Requirements
- R1: `kind_o` is a function of the two mode inputs, where a mode of 0 means bare. Both bare gives 0 (bypass). A bare first stage with a non-bare guest stage gives 2 (guest-stage only). A non-bare first stage with a bare guest stage gives 1 (single stage). Neither bare gives 3 (nested).
- R2: `lk_ready` is 1 at all times. A lookup accepted at a clock edge produces `rsp_valid`=1 right after that edge, and `rsp_valid` is 0 after edges with no lookup.
- R3: A lookup hits only when the kind, guest ID, process ID and page number all equal a stored entry whose permission is not 0. On a hit the response returns that entry's physical page and permission. On a miss, `rsp_hit`, `rsp_ppn` and `rsp_perm` are all 0.
- R4: After reset every entry holds permission 0, so every lookup misses.
- R5: An invalidation always requires the kind to match. It compares the guest ID only when `inv_use_gscid`=1, the process ID only when `inv_use_pscid`=1, and the page number only when `inv_use_vpn`=1. Every matching entry gets permission 0, and all other entries are unchanged.
- R6: A lookup in the same cycle as an invalidation sees the state after that invalidation.
- R7: A fill whose key equals that of a live entry overwrites that entry in place, and the next lookup returns the new page and permission.
- R8: A fill with a new key goes to the entry under a round-robin pointer. The pointer starts at 0 after reset and advances only on such fills. The ninth new key after reset therefore evicts the first.
- R9: A fill is visible to lookups from the next cycle on. When a fill and an invalidation share a cycle, the invalidation acts on the old contents and the filled entry keeps the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fs_mode | input | 4 | First-stage mode field (0 = bare) |
| gs_mode | input | 4 | Guest-stage mode field (0 = bare) |
| kind_o | output | 2 | Derived translation kind |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request ready (always 1) |
| lk_kind | input | 2 | Lookup translation kind |
| lk_gscid | input | 16 | Lookup guest context ID |
| lk_pscid | input | 20 | Lookup process context ID |
| lk_vpn | input | 44 | Lookup virtual page number |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_ppn | output | 44 | Physical page number on hit, else 0 |
| rsp_perm | output | 2 | Permission on hit, else 0 |
| fill_valid | input | 1 | Fill strobe |
| fill_kind | input | 2 | Fill translation kind |
| fill_gscid | input | 16 | Fill guest context ID |
| fill_pscid | input | 20 | Fill process context ID |
| fill_vpn | input | 44 | Fill virtual page number |
| fill_ppn | input | 44 | Fill physical page number |
| fill_perm | input | 2 | Fill permission (0 = none) |
| inv_valid | input | 1 | Invalidation strobe |
| inv_kind | input | 2 | Invalidation kind (always compared) |
| inv_gscid | input | 16 | Invalidation guest context ID |
| inv_pscid | input | 20 | Invalidation process context ID |
| inv_vpn | input | 44 | Invalidation page number |
| inv_use_gscid | input | 1 | Compare the guest ID |
| inv_use_pscid | input | 1 | Compare the process ID |
| inv_use_vpn | input | 1 | Compare the page number |

## Verification
`kind_o` is combinational, so the bench reads it in the same half-cycle it sets the modes. A lookup response appears one edge after acceptance: the bench raises `lk_valid` on a falling edge and reads the response on the next falling edge. Fills and invalidations act at the edge where they are presented, so their effects are checked with a lookup issued in a later cycle. The exception is the same-cycle cases, where the lookup is presented alongside the invalidation or the fill and its response is still read one edge later.

// File: rtl/xtc_pkg.sv
package xtc_pkg;
  localparam int KIND_W  = 2;
  localparam int GSCID_W = 16;
  localparam int PSCID_W = 20;
  localparam int VPN_W   = 44;
  localparam int PPN_W   = 44;
  localparam int PERM_W  = 2;

  typedef enum logic [KIND_W-1:0] {
    KIND_BYPASS = 2'd0,
    KIND_SINGLE = 2'd1,
    KIND_GUEST  = 2'd2,
    KIND_NESTED = 2'd3
  } xlat_kind_e;

  typedef struct packed {
    xlat_kind_e         kind;
    logic [GSCID_W-1:0] gscid;
    logic [PSCID_W-1:0] pscid;
    logic [VPN_W-1:0]   vpn;
  } xlat_key_t;

  typedef struct packed {
    xlat_key_t          key;
    logic [PPN_W-1:0]   ppn;
    logic [PERM_W-1:0]  perm;
  } xlat_entry_t;

  typedef struct packed {
    xlat_key_t key;
    logic      use_g;
    logic      use_p;
    logic      use_a;
  } inv_req_t;
endpackage

// File: rtl/xtc_kind_decode.sv
module xtc_kind_decode
  import xtc_pkg::*;
#(
  parameter int          MODE_W    = 4,
  parameter logic [MODE_W-1:0] BARE_CODE = '0
) (
  input  logic [MODE_W-1:0] fs_mode,
  input  logic [MODE_W-1:0] gs_mode,
  output xlat_kind_e        kind
);
  logic fs_bare, gs_bare;

  assign fs_bare = (fs_mode == BARE_CODE);
  assign gs_bare = (gs_mode == BARE_CODE);

  always_comb begin
    unique case ({fs_bare, gs_bare})
      2'b11:   kind = KIND_BYPASS;
      2'b10:   kind = KIND_GUEST;
      2'b01:   kind = KIND_SINGLE;
      default: kind = KIND_NESTED;
    endcase
  end
endmodule

// File: rtl/xtc_rr_victim.sv
module xtc_rr_victim #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  always_ff @(posedge clk) begin
    if (!rst_n)      ptr <= '0;
    else if (adv)    ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  AST_RR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1)) else $error("rr step"); // R8
  AST_RR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(ptr)) else $error("rr hold"); // R8
endmodule

// File: rtl/xtc_entry.sv
module xtc_entry
  import xtc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  xlat_entry_t       wr_data,
  input  logic              inv_valid,
  input  inv_req_t          inv_req,
  input  xlat_key_t         probe,
  output logic              probe_hit,
  output logic              fill_hit,
  output logic              inv_hit,
  output logic [PPN_W-1:0]  ppn_o,
  output logic [PERM_W-1:0] perm_o
);
  xlat_entry_t ent_q;
  logic        live;
  logic        g_ok, p_ok, a_ok;

  assign live      = (ent_q.perm != '0);
  assign probe_hit = live && (ent_q.key == probe);
  assign fill_hit  = live && (ent_q.key == wr_data.key);

  assign g_ok = !inv_req.use_g || (ent_q.key.gscid == inv_req.key.gscid);
  assign p_ok = !inv_req.use_p || (ent_q.key.pscid == inv_req.key.pscid);
  assign a_ok = !inv_req.use_a || (ent_q.key.vpn   == inv_req.key.vpn);
  assign inv_hit = inv_valid && live && (ent_q.key.kind == inv_req.key.kind)
                   && g_ok && p_ok && a_ok;

  assign ppn_o  = ent_q.ppn;
  assign perm_o = ent_q.perm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_q <= '0;
    end else if (wr_en) begin
      ent_q <= wr_data;
    end else if (inv_hit) begin
      ent_q.perm <= '0;
    end
  end

  AST_INV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_hit && !wr_en) |=> (perm_o == '0)) else $error("inv clear"); // R5
  AST_KEY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ent_q.key) && $stable(ppn_o)) else $error("key hold"); // R7
  AST_FILL_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (perm_o == $past(wr_data.perm))) else $error("fill write"); // R9
endmodule

// File: rtl/xlat_tag_cache.sv
module xlat_tag_cache
  import xtc_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int MODE_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [MODE_W-1:0]  fs_mode,
  input  logic [MODE_W-1:0]  gs_mode,
  output logic [KIND_W-1:0]  kind_o,
  input  logic               lk_valid,
  output logic               lk_ready,
  input  logic [KIND_W-1:0]  lk_kind,
  input  logic [GSCID_W-1:0] lk_gscid,
  input  logic [PSCID_W-1:0] lk_pscid,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic [PPN_W-1:0]   rsp_ppn,
  output logic [PERM_W-1:0]  rsp_perm,
  input  logic               fill_valid,
  input  logic [KIND_W-1:0]  fill_kind,
  input  logic [GSCID_W-1:0] fill_gscid,
  input  logic [PSCID_W-1:0] fill_pscid,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [PPN_W-1:0]   fill_ppn,
  input  logic [PERM_W-1:0]  fill_perm,
  input  logic               inv_valid,
  input  logic [KIND_W-1:0]  inv_kind,
  input  logic [GSCID_W-1:0] inv_gscid,
  input  logic [PSCID_W-1:0] inv_pscid,
  input  logic [VPN_W-1:0]   inv_vpn,
  input  logic               inv_use_gscid,
  input  logic               inv_use_pscid,
  input  logic               inv_use_vpn
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  xlat_kind_e  kind_dec;
  xlat_key_t   probe;
  xlat_entry_t wr_data;
  inv_req_t    inv_req;

  logic [ENTRIES-1:0] probe_hit, fill_hit, inv_hit, live_hit, wr_sel;
  logic [PPN_W-1:0]   ent_ppn  [ENTRIES];
  logic [PERM_W-1:0]  ent_perm [ENTRIES];
  logic [IDX_W-1:0]   victim;
  logic               any_fill_hit;
  logic [PPN_W-1:0]   rd_ppn;
  logic [PERM_W-1:0]  rd_perm;

  xtc_kind_decode #(.MODE_W(MODE_W)) u_decode (
    .fs_mode (fs_mode),
    .gs_mode (gs_mode),
    .kind    (kind_dec)
  );
  assign kind_o   = kind_dec;
  assign lk_ready = 1'b1;

  assign probe   = '{kind: xlat_kind_e'(lk_kind), gscid: lk_gscid,
                     pscid: lk_pscid, vpn: lk_vpn};
  assign wr_data = '{key: '{kind: xlat_kind_e'(fill_kind), gscid: fill_gscid,
                            pscid: fill_pscid, vpn: fill_vpn},
                     ppn: fill_ppn, perm: fill_perm};
  assign inv_req = '{key: '{kind: xlat_kind_e'(inv_kind), gscid: inv_gscid,
                            pscid: inv_pscid, vpn: inv_vpn},
                     use_g: inv_use_gscid, use_p: inv_use_pscid,
                     use_a: inv_use_vpn};

  assign any_fill_hit = |fill_hit;

  xtc_rr_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (fill_valid && !any_fill_hit),
    .ptr   (victim)
  );

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign wr_sel[i] = fill_valid &&
                       (any_fill_hit ? fill_hit[i] : (victim == IDX_W'(i)));
    assign live_hit[i] = probe_hit[i] && !inv_hit[i];

    xtc_entry u_entry (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_sel[i]),
      .wr_data   (wr_data),
      .inv_valid (inv_valid),
      .inv_req   (inv_req),
      .probe     (probe),
      .probe_hit (probe_hit[i]),
      .fill_hit  (fill_hit[i]),
      .inv_hit   (inv_hit[i]),
      .ppn_o     (ent_ppn[i]),
      .perm_o    (ent_perm[i])
    );
  end

  always_comb begin
    rd_ppn  = '0;
    rd_perm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (live_hit[i]) begin
        rd_ppn  = rd_ppn  | ent_ppn[i];
        rd_perm = rd_perm | ent_perm[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_ppn   <= '0;
      rsp_perm  <= '0;
    end else begin
      rsp_valid <= lk_valid;
      rsp_hit   <= lk_valid && (|live_hit);
      rsp_ppn   <= lk_valid ? rd_ppn  : '0;
      rsp_perm  <= lk_valid ? rd_perm : '0;
    end
  end

  AST_PROBE_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(probe_hit)) else $error("multi hit"); // R3
  AST_FILL_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fill_hit)) else $error("duplicate key"); // R7
  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> $countones(wr_sel) == 1) else $error("fill select"); // R8
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_ppn == '0 && rsp_perm == '0)) else $error("miss data"); // R3
  AST_RSP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid) else $error("rsp late"); // R2
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid) else $error("rsp spurious"); // R2
endmodule

// File: tb/xlat_tag_cache_tb.sv
`timescale 1ns/1ps
module xlat_tag_cache_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [3:0]  fs_mode = '0, gs_mode = '0;
  logic [1:0]  kind_o;
  logic        lk_valid = 0, lk_ready;
  logic [1:0]  lk_kind = '0;
  logic [15:0] lk_gscid = '0;
  logic [19:0] lk_pscid = '0;
  logic [43:0] lk_vpn = '0;
  logic        rsp_valid, rsp_hit;
  logic [43:0] rsp_ppn;
  logic [1:0]  rsp_perm;
  logic        fill_valid = 0;
  logic [1:0]  fill_kind = '0;
  logic [15:0] fill_gscid = '0;
  logic [19:0] fill_pscid = '0;
  logic [43:0] fill_vpn = '0, fill_ppn = '0;
  logic [1:0]  fill_perm = '0;
  logic        inv_valid = 0;
  logic [1:0]  inv_kind = '0;
  logic [15:0] inv_gscid = '0;
  logic [19:0] inv_pscid = '0;
  logic [43:0] inv_vpn = '0;
  logic        inv_use_gscid = 0, inv_use_pscid = 0, inv_use_vpn = 0;

  int total = 0, fails = 0;
  bit done = 0;

  xlat_tag_cache u_dut (.*);

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    lk_valid = 0; fill_valid = 0; inv_valid = 0;
  endtask

  task automatic set_look(logic [1:0] k, logic [15:0] g, logic [19:0] p, logic [43:0] v);
    lk_valid = 1; lk_kind = k; lk_gscid = g; lk_pscid = p; lk_vpn = v;
  endtask

  task automatic set_fill(logic [1:0] k, logic [15:0] g, logic [19:0] p, logic [43:0] v,
                          logic [43:0] pp, logic [1:0] pm);
    fill_valid = 1; fill_kind = k; fill_gscid = g; fill_pscid = p; fill_vpn = v;
    fill_ppn = pp; fill_perm = pm;
  endtask

  task automatic set_inv(logic [1:0] k, logic [15:0] g, logic [19:0] p, logic [43:0] v,
                         bit ug, bit up, bit ua);
    inv_valid = 1; inv_kind = k; inv_gscid = g; inv_pscid = p; inv_vpn = v;
    inv_use_gscid = ug; inv_use_pscid = up; inv_use_vpn = ua;
  endtask

  task automatic do_fill(logic [1:0] k, logic [15:0] g, logic [19:0] p, logic [43:0] v,
                         logic [43:0] pp, logic [1:0] pm);
    @(negedge clk); set_fill(k, g, p, v, pp, pm);
    @(negedge clk); idle();
  endtask

  task automatic do_inv(logic [1:0] k, logic [15:0] g, logic [19:0] p, logic [43:0] v,
                        bit ug, bit up, bit ua);
    @(negedge clk); set_inv(k, g, p, v, ug, up, ua);
    @(negedge clk); idle();
  endtask

  // response of a lookup that was set before this call's falling edge
  task automatic chk_rsp(string req, bit eh, logic [43:0] ep, logic [1:0] em);
    chk(rsp_valid == 1'b1, {req, " rsp_valid"}, 64'(rsp_valid), 64'd1);
    chk(rsp_hit == eh, {req, " hit"}, 64'(rsp_hit), 64'(eh));
    chk(rsp_ppn == ep, {req, " ppn"}, 64'(rsp_ppn), 64'(ep));
    chk(rsp_perm == em, {req, " perm"}, 64'(rsp_perm), 64'(em));
  endtask

  task automatic look(string req, logic [1:0] k, logic [15:0] g, logic [19:0] p,
                      logic [43:0] v, bit eh, logic [43:0] ep, logic [1:0] em);
    @(negedge clk); set_look(k, g, p, v);
    @(negedge clk); idle();
    chk_rsp(req, eh, ep, em);
  endtask

  task automatic do_reset();
    @(negedge clk); idle(); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic t_reset();
    do_reset();
    chk(rsp_valid == 0, "R2 idle rsp_valid", 64'(rsp_valid), 0);
    chk(lk_ready == 1, "R2 lk_ready", 64'(lk_ready), 1);
    look("R4 after reset", 2'd0, 16'd0, 20'd0, 44'd0, 0, 0, 0);
    @(negedge clk);
    chk(rsp_valid == 0, "R2 no lookup no rsp", 64'(rsp_valid), 0);
  endtask

  task automatic t_kind();
    fs_mode = 0; gs_mode = 0; #1 chk(kind_o == 2'd0, "R1 bypass", 64'(kind_o), 0);
    fs_mode = 0; gs_mode = 8; #1 chk(kind_o == 2'd2, "R1 guest only", 64'(kind_o), 2);
    fs_mode = 9; gs_mode = 0; #1 chk(kind_o == 2'd1, "R1 single", 64'(kind_o), 1);
    fs_mode = 8; gs_mode = 9; #1 chk(kind_o == 2'd3, "R1 nested", 64'(kind_o), 3);
  endtask

  task automatic t_lookup_fields();
    do_reset();
    do_fill(2'd1, 16'd5, 20'd7, 44'h123, 44'hABC, 2'd3);
    look("R3 exact hit", 2'd1, 16'd5, 20'd7, 44'h123, 1, 44'hABC, 2'd3);
    look("R3 kind differs", 2'd3, 16'd5, 20'd7, 44'h123, 0, 0, 0);
    look("R3 gscid differs", 2'd1, 16'd6, 20'd7, 44'h123, 0, 0, 0);
    look("R3 pscid differs", 2'd1, 16'd5, 20'd8, 44'h123, 0, 0, 0);
    look("R3 vpn differs", 2'd1, 16'd5, 20'd7, 44'h124, 0, 0, 0);
    do_fill(2'd0, 16'd1, 20'd1, 44'h55, 44'h99, 2'd0);
    look("R3 perm none misses", 2'd0, 16'd1, 20'd1, 44'h55, 0, 0, 0);
  endtask

  task automatic t_inval_scope();
    do_reset();
    do_fill(2'd1, 16'd5, 20'd7, 44'h10, 44'hA1, 2'd3);
    do_fill(2'd3, 16'd5, 20'd7, 44'h10, 44'hB1, 2'd1);
    do_fill(2'd1, 16'd5, 20'd8, 44'h11, 44'hC1, 2'd2);
    do_inv(2'd1, 16'd0, 20'd7, 44'h0, 0, 1, 0);
    look("R5 pscid scope kills single", 2'd1, 16'd5, 20'd7, 44'h10, 0, 0, 0);
    look("R5 nested kept by kind", 2'd3, 16'd5, 20'd7, 44'h10, 1, 44'hB1, 2'd1);
    look("R5 other pscid kept", 2'd1, 16'd5, 20'd8, 44'h11, 1, 44'hC1, 2'd2);
    do_inv(2'd3, 16'd6, 20'd0, 44'h10, 1, 0, 1);
    look("R5 gscid mismatch keeps", 2'd3, 16'd5, 20'd7, 44'h10, 1, 44'hB1, 2'd1);
    do_inv(2'd3, 16'd5, 20'd0, 44'h10, 1, 0, 1);
    look("R5 gscid+vpn kills", 2'd3, 16'd5, 20'd7, 44'h10, 0, 0, 0);
    do_inv(2'd1, 16'd0, 20'd0, 44'h0, 0, 0, 0);
    look("R5 kind-wide kills", 2'd1, 16'd5, 20'd8, 44'h11, 0, 0, 0);
  endtask

  task automatic t_same_cycle_inval();
    do_reset();
    do_fill(2'd2, 16'd3, 20'd4, 44'h77, 44'hD1, 2'd1);
    do_fill(2'd0, 16'd3, 20'd4, 44'h77, 44'hD2, 2'd2);
    @(negedge clk);
    set_inv(2'd2, 16'd0, 20'd0, 44'h77, 0, 0, 1);
    set_look(2'd2, 16'd3, 20'd4, 44'h77);
    @(negedge clk); idle();
    chk_rsp("R6 lookup sees invalidation", 0, 0, 0);
    @(negedge clk);
    set_inv(2'd2, 16'd0, 20'd0, 44'h0, 0, 0, 0);
    set_look(2'd0, 16'd3, 20'd4, 44'h77);
    @(negedge clk); idle();
    chk_rsp("R6 other kind survives", 1, 44'hD2, 2'd2);
  endtask

  task automatic t_overwrite();
    do_reset();
    do_fill(2'd3, 16'd9, 20'd9, 44'h200, 44'h111, 2'd1);
    do_fill(2'd3, 16'd9, 20'd9, 44'h200, 44'h222, 2'd3);
    look("R7 overwrite in place", 2'd3, 16'd9, 20'd9, 44'h200, 1, 44'h222, 2'd3);
    // overwrite must not advance the pointer: 7 more new keys leave the first alive
    for (int i = 1; i < 8; i++) do_fill(2'd3, 16'd9, 20'd9, 44'h200 + 44'(i), 44'h300, 2'd1);
    look("R7 no extra slot used", 2'd3, 16'd9, 20'd9, 44'h200, 1, 44'h222, 2'd3);
  endtask

  task automatic t_round_robin();
    do_reset();
    for (int i = 0; i < 9; i++) do_fill(2'd1, 16'd2, 20'd2, 44'h100 + 44'(i), 44'h500 + 44'(i), 2'd1);
    look("R8 first evicted", 2'd1, 16'd2, 20'd2, 44'h100, 0, 0, 0);
    look("R8 second kept", 2'd1, 16'd2, 20'd2, 44'h101, 1, 44'h501, 2'd1);
    look("R8 ninth present", 2'd1, 16'd2, 20'd2, 44'h108, 1, 44'h508, 2'd1);
  endtask

  task automatic t_fill_timing();
    do_reset();
    @(negedge clk);
    set_fill(2'd0, 16'd1, 20'd1, 44'h5, 44'hE5, 2'd2);
    set_look(2'd0, 16'd1, 20'd1, 44'h5);
    @(negedge clk); idle();
    chk_rsp("R9 fill not seen same cycle", 0, 0, 0);
    look("R9 fill seen next cycle", 2'd0, 16'd1, 20'd1, 44'h5, 1, 44'hE5, 2'd2);
    @(negedge clk);
    set_inv(2'd0, 16'd0, 20'd0, 44'h0, 0, 0, 0);
    set_fill(2'd0, 16'd1, 20'd1, 44'h6, 44'hE6, 2'd1);
    @(negedge clk); idle();
    look("R9 old entry invalidated", 2'd0, 16'd1, 20'd1, 44'h5, 0, 0, 0);
    look("R9 fill wins over inval", 2'd0, 16'd1, 20'd1, 44'h6, 1, 44'hE6, 2'd1);
  endtask

  initial begin
    t_reset();
    t_kind();
    t_lookup_fields();
    t_inval_scope();
    t_same_cycle_inval();
    t_overwrite();
    t_round_robin();
    t_fill_timing();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule